// File: doc/BRIEF.md
# Double-Precision Compare with Status Strobes

This block takes two IEEE-754 double-precision operands and decides how they relate. The answer is a one-hot 4-bit condition code: less-than, greater-than, equal or unordered. Next to the code, the block works out how a 32-bit floating-point status word has to change. It does not hold that word. It emits a set mask and a clear mask, and the owner of the status register applies them: it clears the masked bits and then sets the masked bits. The status word is viewed as eight 4-bit nibbles, and nibble n occupies bits [4n+3:4n].

A mode input picks between the two compare flavours, and the flavours differ only in how they report a NaN operand:

- **Quiet flavour** (`ordered_i` = 0) flags the NaN in nibble 4 and nibble 6.
- **Signalling flavour** (`ordered_i` = 1) always clears the low flag of nibble 4. On a NaN it then raises the low and high flags of nibble 4.

A request is presented with `valid_i`. The result, the masks and `res_valid_o` appear one clock later.

Top module: `fp_dcmp`

## Requirements
- R1: An operand whose 11-bit exponent (bits 62:52) is all ones and whose 52-bit fraction is nonzero is a NaN. If either operand is a NaN, the code is 4'b0001. An infinity (zero fraction) is not a NaN.
- R2: When A is less than B and neither is a NaN, the code is 4'b1000.
- R3: When A is greater than B and neither is a NaN, the code is 4'b0100.
- R4: When A equals B, the code is 4'b0010. Positive zero and negative zero are equal.
- R5: When both operands are negative, the operand with the larger magnitude is the smaller. When the signs differ and the operands are not both zero, the negative operand is the smaller.
- R6: Every accepted compare rewrites nibble 3 with the code: set mask bits [15:12] equal the code and clear mask bits [15:12] equal its complement.
- R7: In quiet mode, a NaN compare adds set bits 16 and 24. Quiet mode clears no bit outside nibble 3.
- R8: In signalling mode, a non-NaN compare adds clear bit 16. A NaN compare instead adds set bits 16 and 19 and leaves bit 16 out of the clear mask. No bit is ever in both masks.
- R9: In a cycle after which `valid_i` was low, `res_valid_o` is 0 and both masks are zero, whatever the operands and mode were.
- R10: Results appear on the clock edge after the request is accepted. After reset, `code_o`, both masks and `res_valid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Compare request |
| ordered_i | input | 1 | 1 = signalling flavour, 0 = quiet flavour |
| a_i | input | 64 | Operand A, IEEE-754 double |
| b_i | input | 64 | Operand B, IEEE-754 double |
| res_valid_o | output | 1 | Result and masks valid |
| code_o | output | 4 | One-hot condition code |
| stat_set_o | output | 32 | Status bits to set |
| stat_clr_o | output | 32 | Status bits to clear |

## Verification
A single accepted compare writes the nibble-3 code and, in the same cycle, updates the exception flags in nibble 4. In signalling mode this means a set and a clear aim at the same bit 16. The bench provokes that case with quiet and signalling NaNs, including NaN against infinity. For each one it checks that bit 16 appears only in the set mask, and that the nibble-3 set and clear fields are exact complements of each other.

// File: rtl/fp_dcmp_pkg.sv
package fp_dcmp_pkg;
   typedef logic [3:0] cc_t;
   localparam cc_t CC_LT  = 4'b1000;
   localparam cc_t CC_GT  = 4'b0100;
   localparam cc_t CC_EQ  = 4'b0010;
   localparam cc_t CC_UN  = 4'b0001;
   localparam cc_t CC_OFF = 4'b0000;
endpackage

// File: rtl/fp_dcmp_classify.sv
module fp_dcmp_classify #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0]   op_i,
   output logic           nan_o,
   output logic           zero_o,
   output logic           neg_o,
   output logic [W-2:0]   mag_o
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   assign exp_f  = op_i[W-2 -: EXP_W];
   assign frac_f = op_i[FRAC_W-1:0];
   assign neg_o  = op_i[W-1];
   assign mag_o  = op_i[W-2:0];
   assign nan_o  = (&exp_f) && (|frac_f);
   assign zero_o = ~|mag_o;
endmodule

// File: rtl/fp_dcmp_order.sv
module fp_dcmp_order
   import fp_dcmp_pkg::*;
#(
   parameter int MAG_W = 63
) (
   input  logic             a_nan_i,
   input  logic             b_nan_i,
   input  logic             a_zero_i,
   input  logic             b_zero_i,
   input  logic             a_neg_i,
   input  logic             b_neg_i,
   input  logic [MAG_W-1:0] a_mag_i,
   input  logic [MAG_W-1:0] b_mag_i,
   output cc_t              cc_o
);
   logic mag_lt, mag_gt;

   assign mag_lt = a_mag_i < b_mag_i;
   assign mag_gt = a_mag_i > b_mag_i;

   always_comb begin
      if (a_nan_i || b_nan_i)                cc_o = CC_UN;
      else if (a_zero_i && b_zero_i)         cc_o = CC_EQ;
      else if (a_neg_i != b_neg_i)           cc_o = a_neg_i ? CC_LT : CC_GT;
      else if (!mag_lt && !mag_gt)           cc_o = CC_EQ;
      else if (a_neg_i)                      cc_o = mag_gt ? CC_LT : CC_GT;
      else                                   cc_o = mag_lt ? CC_LT : CC_GT;
   end
endmodule

// File: rtl/fp_dcmp_status.sv
module fp_dcmp_status
   import fp_dcmp_pkg::*;
#(
   parameter int STAT_W   = 32,
   parameter int CC_NIB   = 3,
   parameter int EXC_NIB  = 4,
   parameter int AUX_NIB  = 6
) (
   input  logic              valid_i,
   input  logic              ordered_i,
   input  cc_t               cc_i,
   output logic [STAT_W-1:0] set_o,
   output logic [STAT_W-1:0] clr_o
);
   localparam int CC_LSB  = 4 * CC_NIB;
   localparam int EXC_LSB = 4 * EXC_NIB;
   localparam int AUX_LSB = 4 * AUX_NIB;

   initial begin
      assert (STAT_W >= 4 * (AUX_NIB + 1) && STAT_W >= 4 * (EXC_NIB + 1)
              && STAT_W >= 4 * (CC_NIB + 1))
         else $error("status word too narrow for the nibbles used");
      assert (CC_NIB != EXC_NIB && CC_NIB != AUX_NIB && EXC_NIB != AUX_NIB)
         else $error("status nibbles must be distinct");
   end

   logic unord;
   assign unord = (cc_i == CC_UN);

   always_comb begin
      set_o = '0;
      clr_o = '0;
      if (valid_i) begin
         set_o[CC_LSB +: 4] = cc_i;
         clr_o[CC_LSB +: 4] = ~cc_i;
         if (ordered_i) begin
            if (unord) begin
               set_o[EXC_LSB]     = 1'b1;
               set_o[EXC_LSB + 3] = 1'b1;
            end else begin
               clr_o[EXC_LSB]     = 1'b1;
            end
         end else if (unord) begin
            set_o[EXC_LSB] = 1'b1;
            set_o[AUX_LSB] = 1'b1;
         end
      end
   end

   // R8: a bit never appears in both masks
   always_comb begin
      p_disjoint_r8: assert ((set_o & clr_o) == '0);
   end
endmodule

// File: rtl/fp_dcmp.sv
module fp_dcmp
   import fp_dcmp_pkg::*;
#(
   parameter int EXP_W   = 11,
   parameter int FRAC_W  = 52,
   parameter int STAT_W  = 32,
   parameter int CC_NIB  = 3,
   parameter int EXC_NIB = 4,
   parameter int AUX_NIB = 6,
   localparam int W      = 1 + EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic              ordered_i,
   input  logic [63:0]       a_i,
   input  logic [63:0]       b_i,
   output logic              res_valid_o,
   output logic [3:0]        code_o,
   output logic [STAT_W-1:0] stat_set_o,
   output logic [STAT_W-1:0] stat_clr_o
);
   initial begin
      assert (W == 64) else $error("operand format must total 64 bits");
   end

   logic [1:0]   nan_v, zero_v, neg_v;
   logic [W-2:0] mag_v [2];
   logic [W-1:0] ops   [2];

   assign ops[0] = a_i;
   assign ops[1] = b_i;

   for (genvar k = 0; k < 2; k++) begin : g_cls
      fp_dcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .op_i   (ops[k]),
         .nan_o  (nan_v[k]),
         .zero_o (zero_v[k]),
         .neg_o  (neg_v[k]),
         .mag_o  (mag_v[k])
      );
   end

   cc_t               cc_d;
   logic [STAT_W-1:0] set_d, clr_d;

   fp_dcmp_order #(.MAG_W(W-1)) u_ord (
      .a_nan_i  (nan_v[0]),
      .b_nan_i  (nan_v[1]),
      .a_zero_i (zero_v[0]),
      .b_zero_i (zero_v[1]),
      .a_neg_i  (neg_v[0]),
      .b_neg_i  (neg_v[1]),
      .a_mag_i  (mag_v[0]),
      .b_mag_i  (mag_v[1]),
      .cc_o     (cc_d)
   );

   fp_dcmp_status #(
      .STAT_W(STAT_W), .CC_NIB(CC_NIB), .EXC_NIB(EXC_NIB), .AUX_NIB(AUX_NIB)
   ) u_st (
      .valid_i   (valid_i),
      .ordered_i (ordered_i),
      .cc_i      (cc_d),
      .set_o     (set_d),
      .clr_o     (clr_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid_o <= 1'b0;
         code_o      <= CC_OFF;
         stat_set_o  <= '0;
         stat_clr_o  <= '0;
      end else begin
         res_valid_o <= valid_i;
         code_o      <= valid_i ? cc_d : code_o;
         stat_set_o  <= set_d;
         stat_clr_o  <= clr_d;
      end
   end

   p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> res_valid_o);
   p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> $countones(code_o) == 1);
   p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid_o |-> (stat_set_o == '0 && stat_clr_o == '0));
   p_nan_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (nan_v != 2'b00)) |=> code_o == CC_UN);
   p_quiet_noclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !ordered_i) |=> stat_clr_o[4*EXC_NIB] == 1'b0);
endmodule

// File: tb/fp_dcmp_test.sv
module fp_dcmp_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic        ordered_i = 1'b0;
   logic [63:0] a_i = '0, b_i = '0;
   logic        res_valid_o;
   logic [3:0]  code_o;
   logic [31:0] stat_set_o, stat_clr_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   fp_dcmp uut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .ordered_i(ordered_i),
      .a_i(a_i), .b_i(b_i), .res_valid_o(res_valid_o), .code_o(code_o),
      .stat_set_o(stat_set_o), .stat_clr_o(stat_clr_o)
   );

   localparam logic [63:0] P1 = 64'h3FF0000000000000, P2 = 64'h4000000000000000;
   localparam logic [63:0] N1 = 64'hBFF0000000000000, N2 = 64'hC000000000000000;
   localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000000000000000;
   localparam logic [63:0] QN = 64'h7FF8000000000000, SN = 64'h7FF0000000000001;
   localparam logic [63:0] PI = 64'h7FF0000000000000, NI = 64'hFFF0000000000000;
   localparam logic [63:0] DN = 64'h0000000000000001, NN = 64'hFFF8000000000000;

   // {a, b, ordered, expected code}
   localparam int NV = 16;
   localparam logic [132:0] VEC [NV] = '{
      {P1, P2, 1'b0, 4'b1000},   // R2
      {P2, P1, 1'b0, 4'b0100},   // R3
      {P1, P1, 1'b1, 4'b0010},   // R4
      {PZ, NZ, 1'b0, 4'b0010},   // R4 +0 == -0
      {NZ, PZ, 1'b1, 4'b0010},   // R4
      {N2, N1, 1'b0, 4'b1000},   // R5
      {N1, N2, 1'b1, 4'b0100},   // R5
      {N1, P1, 1'b0, 4'b1000},   // R5 sign differs
      {DN, NZ, 1'b1, 4'b0100},   // R5
      {PI, P2, 1'b1, 4'b0100},   // R1 inf not NaN
      {NI, PI, 1'b0, 4'b1000},   // R1
      {QN, P1, 1'b0, 4'b0001},   // R1 R7
      {P1, SN, 1'b0, 4'b0001},   // R1 R7
      {QN, PI, 1'b1, 4'b0001},   // R1 R8
      {NN, NN, 1'b1, 4'b0001},   // R1 R8
      {PZ, QN, 1'b1, 4'b0001}    // R8
   };

   function automatic logic [31:0] exp_set(logic [3:0] cc, logic ord);
      logic [31:0] m = '0;
      m[15:12] = cc;
      if (cc == 4'b0001) begin
         m[16] = 1'b1;
         if (ord) m[19] = 1'b1; else m[24] = 1'b1;
      end
      return m;
   endfunction

   function automatic logic [31:0] exp_clr(logic [3:0] cc, logic ord);
      logic [31:0] m = '0;
      m[15:12] = ~cc;
      if (ord && cc != 4'b0001) m[16] = 1'b1;
      return m;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic drive(logic v, logic ord, logic [63:0] a, logic [63:0] b);
      @(negedge clk);
      valid_i = v; ordered_i = ord; a_i = a; b_i = b;
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 reset valid", {31'b0, res_valid_o}, 32'h0);
      check("R10 reset code", {28'b0, code_o}, 32'h0);
      check("R10 reset set", stat_set_o, 32'h0);
      check("R10 reset clr", stat_clr_o, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [63:0] a = VEC[i][132:69];
         logic [63:0] b = VEC[i][68:5];
         logic        o = VEC[i][4];
         logic [3:0]  c = VEC[i][3:0];
         drive(1'b1, o, a, b);
         // R10 one-cycle latency: sampled at negedge after capture edge
         check($sformatf("R10 vec%0d valid", i), {31'b0, res_valid_o}, 32'h1);
         check($sformatf("R1-5 vec%0d code", i), {28'b0, code_o}, {28'b0, c});
         check($sformatf("R6 R7 R8 vec%0d set", i), stat_set_o, exp_set(c, o));
         check($sformatf("R6 R7 R8 vec%0d clr", i), stat_clr_o, exp_clr(c, o));
         check($sformatf("R8 vec%0d overlap", i), stat_set_o & stat_clr_o, 32'h0);
      end

      // R9: NaN with valid low produces nothing
      drive(1'b0, 1'b0, QN, QN);
      check("R9 idle valid", {31'b0, res_valid_o}, 32'h0);
      check("R9 idle set", stat_set_o, 32'h0);
      check("R9 idle clr", stat_clr_o, 32'h0);
      drive(1'b0, 1'b1, P1, P2);
      check("R9 idle ordered set", stat_set_o, 32'h0);
      check("R9 idle ordered clr", stat_clr_o, 32'h0);

      // R8: back-to-back signalling compares, NaN then ordinary
      @(negedge clk);
      valid_i = 1'b1; ordered_i = 1'b1; a_i = SN; b_i = P1;
      @(negedge clk);
      check("R8 b2b nan set", stat_set_o, exp_set(4'b0001, 1'b1));
      a_i = P2; b_i = P1;
      @(negedge clk);
      valid_i = 1'b0;
      check("R8 b2b clr bit16", stat_clr_o, exp_clr(4'b0100, 1'b1));
      check("R3 b2b code", {28'b0, code_o}, 32'h4);

      // R10: mid-run reset clears outputs
      drive(1'b1, 1'b0, QN, P1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 re-reset code", {28'b0, code_o}, 32'h0);
      check("R10 re-reset set", stat_set_o, 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule